// File: doc/BRIEF.md
# Programmable-Logic Configuration Store with User Signature and Readback Lock

This block holds the full configuration pattern of a small programmable sum-of-products logic device: the AND-array connections, the per-cell mode bits, the per-term enable bits and the two global mode bits. The whole pattern is driven out in parallel to the array and macrocell logic. A few fields are also broken out as named buses for the cell mode decode. A single-bit addressed port programs the pattern and reads it back. Programming follows the rules of a non-volatile cell. A bulk erase puts every bit at 1. An individual write can only pull a bit from 1 to 0.

Part of the address space is a 64-bit user signature row. Software may keep any identification data there, and that row can be read back at all times. One address beyond the pattern holds a security cell. Once that cell is programmed, the logic and mode regions of the pattern read back as all ones. The signature row still reads its true contents. The configured logic keeps working while the cell is programmed. Only a bulk erase returns the security cell to its unprogrammed state.

Top module: `cfg_store`

## Requirements
- R1: After reset every pattern bit reads 1 on `cfg_pattern`, `locked` is 0 and `rvalid` is 0.
- R2: A write (`wr_en`=1, no erase) to an address below 2194 makes the bit the AND of its old value and `wdata`, visible on `cfg_pattern` the next cycle. Writing 1 never changes a 0 back to 1.
- R3: A read request (`rd_en`=1) in cycle n gives `rvalid`=1 and `rdata` in cycle n+1. The value returned is the state before any write or erase in cycle n.
- R4: An erase (`erase`=1) sets every pattern bit to 1 and clears `locked` the next cycle. In the same cycle it overrides any write.
- R5: Writing `wdata`=0 to address 2194 programs the security cell, so `locked` goes to 1 the next cycle. Writing 1 there has no effect, and no write clears it.
- R6: While `locked`=1, reads of addresses 0..2055 and 2120..2193 return 1.
- R7: Reads of the signature row at addresses 2056..2119 return the stored bit whether or not `locked` is set.
- R8: A read of address 2194 returns 0 when locked and 1 when not. Reads above 2194 return 1, and writes above 2194 change nothing.
- R9: `cell_l1[k]` shows pattern bit 2048+k and `cell_l0[k]` shows bit 2120+k, for k = 0..7. `glob_g0` shows bit 2192 and `glob_g1` shows bit 2193.
- R10: The lock affects readback only. Writes while locked still program the pattern, and the change appears on `cfg_pattern`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 12 | Bit address for write or read |
| wdata | input | 1 | Write data bit |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read request |
| erase | input | 1 | Bulk erase strobe |
| rdata | output | 1 | Read data, valid with rvalid |
| rvalid | output | 1 | Read response valid |
| locked | output | 1 | Security cell programmed |
| cfg_pattern | output | 2194 | Whole configuration pattern |
| cell_l1 | output | 8 | Per-cell mode bit L1 |
| cell_l0 | output | 8 | Per-cell mode bit L0 |
| glob_g0 | output | 1 | Global mode bit G0 |
| glob_g1 | output | 1 | Global mode bit G1 |

## Verification
The properties assume that `addr` and `wdata` carry known values in every cycle where a strobe is high. They also assume the strobes are stable across each rising edge, because the masking, lock and erase checks compare the sampled request with the next cycle's outputs. The stimulus changes every input only on the falling clock edge and holds each strobe for exactly one rising edge. It also covers erase and write in the same cycle, and a read of a bit in the same cycle as a write to it, so the checks of same-cycle ordering do not depend on simulation scheduling.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  // Default geometry of the configuration space.
  localparam int unsigned CS_ADDR_W         = 12;
  localparam int unsigned CS_CELLS          = 8;
  localparam int unsigned CS_ARRAY_BITS     = 2048;
  localparam int unsigned CS_SIG_BITS       = 64;
  localparam int unsigned CS_TERMS_PER_CELL = 8;

  // Address region classes used by the write and read paths.
  typedef enum logic [1:0] {
    RGN_LOGIC = 2'd0,  // array, mode and term bits: masked when locked
    RGN_SIG   = 2'd1,  // user signature row: always readable
    RGN_LOCK  = 2'd2,  // security cell
    RGN_VOID  = 2'd3   // outside the space
  } region_e;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_store_pkg::*;
#(
  parameter int unsigned ADDR_W     = CS_ADDR_W,
  parameter int unsigned TOTAL_BITS = 2194,
  parameter int unsigned SIG_BASE   = 2056,
  parameter int unsigned SIG_BITS   = CS_SIG_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] SIG_LO_A = ADDR_W'(SIG_BASE);
  localparam logic [ADDR_W-1:0] SIG_HI_A = ADDR_W'(SIG_BASE + SIG_BITS - 1);
  localparam logic [ADDR_W-1:0] LOCK_A   = ADDR_W'(TOTAL_BITS);

  always_comb begin
    if (addr == LOCK_A) begin
      region = RGN_LOCK;
    end else if (addr > LOCK_A) begin
      region = RGN_VOID;
    end else if ((addr >= SIG_LO_A) && (addr <= SIG_HI_A)) begin
      region = RGN_SIG;
    end else begin
      region = RGN_LOGIC;
    end
  end
endmodule

// File: rtl/cfg_bit_array.sv
module cfg_bit_array #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned TOTAL_BITS = 2194
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  erase,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wdata,
  output logic [TOTAL_BITS-1:0] bits
);
  // One non-volatile-style cell per pattern bit: erase drives 1,
  // a write can only clear.
  for (genvar i = 0; i < TOTAL_BITS; i++) begin : g_cell
    logic hit;
    logic cell_en;
    logic cell_nx;
    logic cell_q;

    always_comb begin
      hit     = wr_en && (addr == ADDR_W'(i));
      cell_en = erase || hit;
      cell_nx = erase ? 1'b1 : (cell_q & wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 1'b1;
      end else if (cell_en) begin
        cell_q <= cell_nx;
      end
    end

    assign bits[i] = cell_q;
  end
endmodule

// File: rtl/cfg_lock_cell.sv
module cfg_lock_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic erase,
  input  logic program_cell,
  output logic locked
);
  logic lock_en;
  logic lock_nx;
  logic lock_q;

  // Erase has priority over programming in the same cycle.
  always_comb begin
    lock_en = erase || program_cell;
    lock_nx = !erase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_nx;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port
  import cfg_store_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned TOTAL_BITS = 2194
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  region_e               region,
  input  logic [TOTAL_BITS-1:0] bits,
  input  logic                  locked,
  output logic                  rdata,
  output logic                  rvalid
);
  logic rdata_nx;
  logic rdata_q;
  logic rvalid_q;

  // Select and mask the requested bit from the current (pre-update) state.
  always_comb begin
    unique case (region)
      RGN_SIG:   rdata_nx = bits[addr];
      RGN_LOGIC: rdata_nx = locked ? 1'b1 : bits[addr];
      RGN_LOCK:  rdata_nx = !locked;
      default:   rdata_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 1'b1;
    end else if (rd_en) begin
      rdata_q <= rdata_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter  int unsigned ADDR_W         = CS_ADDR_W,
  parameter  int unsigned CELLS          = CS_CELLS,
  parameter  int unsigned ARRAY_BITS     = CS_ARRAY_BITS,
  parameter  int unsigned SIG_BITS       = CS_SIG_BITS,
  parameter  int unsigned TERMS_PER_CELL = CS_TERMS_PER_CELL,
  localparam int unsigned L1_BASE        = ARRAY_BITS,
  localparam int unsigned SIG_BASE       = L1_BASE + CELLS,
  localparam int unsigned L0_BASE        = SIG_BASE + SIG_BITS,
  localparam int unsigned TERM_BASE      = L0_BASE + CELLS,
  localparam int unsigned G0_IDX         = TERM_BASE + CELLS * TERMS_PER_CELL,
  localparam int unsigned G1_IDX         = G0_IDX + 1,
  localparam int unsigned TOTAL_BITS     = G1_IDX + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wdata,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  erase,
  output logic                  rdata,
  output logic                  rvalid,
  output logic                  locked,
  output logic [TOTAL_BITS-1:0] cfg_pattern,
  output logic [CELLS-1:0]      cell_l1,
  output logic [CELLS-1:0]      cell_l0,
  output logic                  glob_g0,
  output logic                  glob_g1
);
  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q;
  logic srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  region_e region;
  logic    wr_pattern;
  logic    wr_lock;

  cfg_addr_decode #(
    .ADDR_W    (ADDR_W),
    .TOTAL_BITS(TOTAL_BITS),
    .SIG_BASE  (SIG_BASE),
    .SIG_BITS  (SIG_BITS)
  ) u_decode (
    .addr  (addr),
    .region(region)
  );

  always_comb begin
    wr_pattern = wr_en && ((region == RGN_LOGIC) || (region == RGN_SIG));
    wr_lock    = wr_en && (region == RGN_LOCK) && !wdata;
  end

  cfg_bit_array #(
    .ADDR_W    (ADDR_W),
    .TOTAL_BITS(TOTAL_BITS)
  ) u_array (
    .clk  (clk),
    .rst_n(srst_n),
    .erase(erase),
    .wr_en(wr_pattern),
    .addr (addr),
    .wdata(wdata),
    .bits (cfg_pattern)
  );

  cfg_lock_cell u_lock (
    .clk         (clk),
    .rst_n       (srst_n),
    .erase       (erase),
    .program_cell(wr_lock),
    .locked      (locked)
  );

  cfg_read_port #(
    .ADDR_W    (ADDR_W),
    .TOTAL_BITS(TOTAL_BITS)
  ) u_read (
    .clk   (clk),
    .rst_n (srst_n),
    .rd_en (rd_en),
    .addr  (addr),
    .region(region),
    .bits  (cfg_pattern),
    .locked(locked),
    .rdata (rdata),
    .rvalid(rvalid)
  );

  // Per-cell mode bit fan-out.
  for (genvar k = 0; k < CELLS; k++) begin : g_cell_mode
    assign cell_l1[k] = cfg_pattern[L1_BASE + k];
    assign cell_l0[k] = cfg_pattern[L0_BASE + k];
  end

  assign glob_g0 = cfg_pattern[G0_IDX];
  assign glob_g1 = cfg_pattern[G1_IDX];
endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CELLS      = 8,
  parameter int unsigned TOTAL_BITS = 2194,
  parameter int unsigned L1_BASE    = 2048,
  parameter int unsigned SIG_BASE   = 2056
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  wdata,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  erase,
  input logic                  rdata,
  input logic                  rvalid,
  input logic                  locked,
  input logic [TOTAL_BITS-1:0] cfg_pattern,
  input logic [CELLS-1:0]      cell_l1
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(TOTAL_BITS);
  localparam logic [ADDR_W-1:0] SIG_A  = ADDR_W'(SIG_BASE);
  localparam logic [ADDR_W-1:0] L1_A   = ADDR_W'(L1_BASE);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);  // R3

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);  // R3

  AST_NO_CLEAR_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((cfg_pattern & ~$past(cfg_pattern)) == '0));  // R2

  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (&cfg_pattern));  // R4

  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !locked);  // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !erase) |=> locked);  // R5

  AST_LOCK_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase && !wdata && (addr == LOCK_A)) |=> locked);  // R5

  AST_LOCKED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && locked && (addr < SIG_A)) |=> rdata);  // R6

  AST_L1_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase && !wdata && (addr == L1_A)) |=> !cell_l1[0]);  // R9

  AST_L1_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (&cell_l1));  // R9
endmodule

bind cfg_store cfg_store_chk #(
  .ADDR_W    (ADDR_W),
  .CELLS     (CELLS),
  .TOTAL_BITS(TOTAL_BITS),
  .L1_BASE   (L1_BASE),
  .SIG_BASE  (SIG_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .addr       (addr),
  .wdata      (wdata),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .erase      (erase),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .locked     (locked),
  .cfg_pattern(cfg_pattern),
  .cell_l1    (cell_l1)
);

// File: tb/tb_cfg_store.sv
module tb_cfg_store;
  localparam int NBITS   = 2194;
  localparam int LOCK_AD = 2194;
  localparam int L1_AD   = 2048;
  localparam int SIG_LO  = 2056;
  localparam int SIG_HI  = 2119;
  localparam int L0_AD   = 2120;
  localparam int G0_AD   = 2192;
  localparam int G1_AD   = 2193;

  logic             clk;
  logic             rst_n;
  logic [11:0]      addr;
  logic             wdata;
  logic             wr_en;
  logic             rd_en;
  logic             erase;
  logic             rdata;
  logic             rvalid;
  logic             locked;
  logic [NBITS-1:0] cfg_pattern;
  logic [7:0]       cell_l1;
  logic [7:0]       cell_l0;
  logic             glob_g0;
  logic             glob_g1;

  cfg_store dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .erase(erase), .rdata(rdata), .rvalid(rvalid),
    .locked(locked), .cfg_pattern(cfg_pattern), .cell_l1(cell_l1),
    .cell_l0(cell_l0), .glob_g0(glob_g0), .glob_g1(glob_g1)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int n_cmp  = 0;
  int n_miss = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  // Reference model, built from the requirements.
  bit m_mem [NBITS];
  bit m_lock;

  bit    exp_q [$];
  string tag_q [$];

  function automatic bit model_read(input int a);
    if (a < NBITS) begin
      if ((a >= SIG_LO) && (a <= SIG_HI)) return m_mem[a];     // R7
      return m_lock ? 1'b1 : m_mem[a];                         // R6
    end
    if (a == LOCK_AD) return !m_lock;                          // R8
    return 1'b1;
  endfunction

  function automatic void model_update(input bit w, input bit e, input int a, input bit d);
    if (e) begin
      for (int i = 0; i < NBITS; i++) m_mem[i] = 1'b1;
      m_lock = 1'b0;
    end else if (w) begin
      if (a < NBITS) m_mem[a] = m_mem[a] & d;
      else if ((a == LOCK_AD) && !d) m_lock = 1'b1;
    end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: one operation per two cycles, expected read data queued.
  task automatic op(input bit w, input bit r, input bit e, input int a, input bit d,
                    input string tag);
    @(negedge clk);
    addr  = a[11:0];
    wdata = d;
    wr_en = w;
    rd_en = r;
    erase = e;
    if (r) begin
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
    end
    model_update(w, e, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    erase = 1'b0;
  endtask

  task automatic wr(input int a, input bit d, input string tag);
    op(1'b1, 1'b0, 1'b0, a, d, tag);
  endtask

  task automatic rd(input int a, input string tag);
    op(1'b0, 1'b1, 1'b0, a, 1'b0, tag);
  endtask

  // Monitor: pops the scoreboard on each response.
  always @(negedge clk) begin
    if (mon_on && rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++;
        n_miss++;
        $display("FAIL R3: actual unexpected response expected none");
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(rdata), int'(e));
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    addr  = '0;
    wdata = 1'b0;
    wr_en = 1'b0;
    rd_en = 1'b0;
    erase = 1'b0;
    for (int i = 0; i < NBITS; i++) m_mem[i] = 1'b1;
    m_lock = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    check("R1 pattern all ones", int'(&cfg_pattern), 1);
    check("R1 locked", int'(locked), 0);
    check("R1 rvalid", int'(rvalid), 0);
    rd(0, "R1 read bit0");
    rd(G1_AD, "R1 read G1");

    // R2 programming 1->0, writes of 1 do not restore
    wr(5, 1'b0, "R2");
    check("R2 bit5 cleared", int'(cfg_pattern[5]), 0);
    wr(5, 1'b1, "R2");
    check("R2 bit5 stays 0", int'(cfg_pattern[5]), 0);
    wr(6, 1'b1, "R2");
    check("R2 bit6 stays 1", int'(cfg_pattern[6]), 1);

    // R9 mode field mapping
    wr(L1_AD + 0, 1'b0, "R9");
    wr(L1_AD + 7, 1'b0, "R9");
    wr(L0_AD + 3, 1'b0, "R9");
    wr(G0_AD, 1'b0, "R9");
    check("R9 cell_l1", int'(cell_l1), 8'h7E);
    check("R9 cell_l0", int'(cell_l0), 8'hF7);
    check("R9 glob_g0", int'(glob_g0), 0);
    check("R9 glob_g1", int'(glob_g1), 1);

    // R7 signature contents
    wr(SIG_LO + 4, 1'b0, "R7");
    wr(SIG_HI, 1'b0, "R7");

    // R3 readback, including read in the same cycle as a write
    rd(5, "R3 read bit5");
    rd(6, "R3 read bit6");
    rd(L0_AD + 3, "R3 read L0[3]");
    op(1'b1, 1'b1, 1'b0, 7, 1'b0, "R3 read-during-write old value");
    rd(7, "R3 read bit7 after write");

    // R8 out-of-space and lock address while unlocked
    wr(3000, 1'b0, "R8");
    rd(3000, "R8 read above space");
    rd(LOCK_AD + 1, "R8 read 2195");
    rd(LOCK_AD, "R8 lock cell unlocked");
    check("R8 no pattern change", int'(cfg_pattern[3000 % NBITS]), 1);

    // R5 lock programming
    wr(LOCK_AD, 1'b1, "R5");
    check("R5 write 1 ignored", int'(locked), 0);
    wr(LOCK_AD, 1'b0, "R5");
    check("R5 locked set", int'(locked), 1);
    wr(LOCK_AD, 1'b1, "R5");
    check("R5 lock sticky", int'(locked), 1);
    rd(LOCK_AD, "R8 lock cell locked");

    // R6 masking, R7 signature visible
    rd(5, "R6 masked logic bit");
    rd(L1_AD, "R6 masked L1");
    rd(G0_AD, "R6 masked G0");
    rd(L0_AD + 3, "R6 masked L0");
    rd(SIG_LO + 4, "R7 signature while locked");
    rd(SIG_HI, "R7 signature top while locked");
    rd(SIG_LO, "R7 signature unwritten");

    // R10 writes while locked still program
    wr(10, 1'b0, "R10");
    check("R10 pattern changed while locked", int'(cfg_pattern[10]), 0);
    rd(10, "R10 readback masked");

    // R4 erase overrides write in same cycle
    op(1'b1, 1'b0, 1'b1, 20, 1'b0, "R4");
    check("R4 all ones", int'(&cfg_pattern), 1);
    check("R4 unlocked", int'(locked), 0);
    rd(5, "R4 read bit5 after erase");
    rd(20, "R4 write lost to erase");

    // Spread pattern
    for (int i = 0; i < 40; i++) wr((i * 53 + 11) % NBITS, 1'b0, "R2");
    for (int i = 0; i < 40; i++) rd((i * 53 + 11) % NBITS, "R3 spread written");
    for (int i = 0; i < 20; i++) rd((i * 53 + 12) % NBITS, "R3 spread neighbour");
    wr(LOCK_AD, 1'b0, "R5");
    for (int i = 0; i < 20; i++) rd((i * 53 + 11) % NBITS, "R6 R7 spread locked");

    repeat (4) @(negedge clk);
    check("R3 all responses seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule